// File: doc/BRIEF.md
# Multi-core run/stop controller

This block starts and halts a set of processors on command from a simple memory-mapped bus. Software writes a bit mask to a run-request register to start processors, or to a stop-request register to halt them. The block compares each request against its own mask of running processors. A processor that is halted and asked to start gets a one-cycle reset pulse and is marked running. A processor that is running and asked to stop gets a one-cycle halt pulse and is marked halted. The running mask can be read back from a status register. The whole register set appears in two address windows, and both copies behave the same.

After reset every processor is marked halted. The sequencer then enters its launch state, `ST_LAUNCH`, for one cycle. In that cycle it applies the parameter `START_MASK` as if it had been written to the run register. It then moves to `ST_SERVE` and stays there until the next reset. That is the only transition (`ST_LAUNCH` to `ST_SERVE`, unconditional). The bus is served in both states. A stop write that arrives in the launch cycle therefore meets the start set in the same cycle, and the stop has priority.

Top module: `vp_run_ctl`

## Requirements
- R1: While `rst_n` is low, `vp_reset`, `vp_halt`, `err_pulse` and `rd_valid` are all 0. In the first cycle after release, every processor in `START_MASK` receives a one-cycle `vp_reset` pulse and is marked running.
- R2: A run write applies `bus_wdata` masked to bits `NUM_VP-1:0`. Each selected processor that is halted gets a `vp_reset` pulse in the cycle after the write edge, and its running bit is set.
- R3: A run write to processors that are already running produces no pulse and leaves the mask unchanged.
- R4: A stop write applies `bus_wdata` masked to bits `NUM_VP-1:0`. Each selected processor that is running gets a `vp_halt` pulse in the cycle after the write edge, and its running bit is cleared.
- R5: A stop write to processors that are halted produces no pulse.
- R6: A status read sets `rd_valid` for one cycle after the access edge. `bus_rdata` then holds the running mask in bits `NUM_VP-1:0`, with every other bit zero.
- R7: Both windows decode identically. The local window is at byte address 0x2000 and the other window is at 0x4000. Within each window, run is at +0x28, stop is at +0x30 and status is at +0x70.
- R8: An access to any other address sets `err_pulse` for one cycle. A write there changes nothing, and a read returns zero.
- R9: When the same bit is requested to run and to stop in the same cycle, the stop wins. This occurs when the launch set meets a stop write in the launch cycle: a halted processor stays halted and gets no pulse.
- R10: A write to a status address is ignored and raises no error. A read from a run or stop address returns zero and raises no error.
- R11: No processor gets a reset pulse and a halt pulse in the same cycle. The running mask changes only where a pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | One-cycle read return strobe |
| err_pulse | output | 1 | One-cycle strobe for an unknown address |
| vp_reset | output | NUM_VP | Per-processor start reset pulse |
| vp_halt | output | NUM_VP | Per-processor halt pulse |

## Verification
The bench targets five mistakes.
- Filtering a command against the wrong mask would pulse processors that are already in the requested state, or skip the ones that are not.
- Masking data above `NUM_VP` wrongly would set phantom running bits, which then appear in status reads.
- Decoding only one window would make the alias write do nothing and flag it as an error.
- Giving run priority over stop in the launch cycle would start a processor that software tried to keep halted.
- Sampling the status after the edge instead of before would return the mask from one access late.

// File: rtl/vpctl_pkg.sv
package vpctl_pkg;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned N_WIN  = 2;

    localparam logic [ADDR_W-1:0] WIN_LOCAL = 16'h2000;
    localparam logic [ADDR_W-1:0] WIN_OTHER = 16'h4000;
    localparam logic [ADDR_W-1:0] OFS_RUN   = 16'h0028;
    localparam logic [ADDR_W-1:0] OFS_STOP  = 16'h0030;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 16'h0070;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_RUN  = 2'd1,
        REG_STOP = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_LAUNCH = 1'b0,
        ST_SERVE  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/vpctl_decode.sv
module vpctl_decode
    import vpctl_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [N_WIN-1:0][ADDR_W-1:0] BASES = {WIN_OTHER, WIN_LOCAL};

    logic [N_WIN-1:0] hit_run;
    logic [N_WIN-1:0] hit_stop;
    logic [N_WIN-1:0] hit_stat;

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        assign hit_run[w]  = (addr == BASES[w] + OFS_RUN);
        assign hit_stop[w] = (addr == BASES[w] + OFS_STOP);
        assign hit_stat[w] = (addr == BASES[w] + OFS_STAT);
    end

    always_comb begin
        if (|hit_run)       sel = REG_RUN;
        else if (|hit_stop) sel = REG_STOP;
        else if (|hit_stat) sel = REG_STAT;
        else                sel = REG_NONE;
    end
endmodule

// File: rtl/vpctl_seq.sv
module vpctl_seq
    import vpctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    output logic       launch,
    output seq_state_e state
);
    seq_state_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_LAUNCH: state_d = ST_SERVE;
            ST_SERVE:  state_d = ST_SERVE;
            default:   state_d = ST_SERVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LAUNCH;
        else        state <= state_d;
    end

    always_comb begin
        unique case (state)
            ST_LAUNCH: launch = 1'b1;
            ST_SERVE:  launch = 1'b0;
            default:   launch = 1'b0;
        endcase
    end
endmodule

// File: rtl/vpctl_vp_slice.sv
module vpctl_vp_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic run_sel,
    input  logic stop_sel,
    output logic running,
    output logic rst_pulse,
    output logic halt_pulse
);
    logic do_start;
    logic do_stop;

    // stop has priority over run on the same bit
    assign do_stop  = stop_sel & running;
    assign do_start = run_sel & ~running & ~stop_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running    <= 1'b0;
            rst_pulse  <= 1'b0;
            halt_pulse <= 1'b0;
        end else begin
            rst_pulse  <= do_start;
            halt_pulse <= do_stop;
            if (do_stop)       running <= 1'b0;
            else if (do_start) running <= 1'b1;
        end
    end
endmodule

// File: rtl/vp_run_ctl.sv
module vp_run_ctl
    import vpctl_pkg::*;
#(
    parameter int unsigned NUM_VP     = 1,
    parameter int unsigned DATA_W     = 64,
    parameter logic [63:0] START_MASK = 64'h1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                rd_valid,
    output logic                err_pulse,
    output logic [NUM_VP-1:0]   vp_reset,
    output logic [NUM_VP-1:0]   vp_halt
);
    if (NUM_VP < 1 || NUM_VP > DATA_W) begin : g_bad_width
        $error("vp_run_ctl: NUM_VP out of range");
    end
    if ((START_MASK >> NUM_VP) != 64'h0) begin : g_bad_start
        $error("vp_run_ctl: START_MASK selects a processor beyond NUM_VP");
    end

    reg_sel_e          sel;
    seq_state_e        state;
    logic              launch;
    logic [NUM_VP-1:0] run_q;
    logic [NUM_VP-1:0] run_req;
    logic [NUM_VP-1:0] stop_req;
    logic [NUM_VP-1:0] wr_bits;
    logic [DATA_W-1:0] stat_word;
    logic              wr_acc;
    logic              rd_acc;

    vpctl_decode u_dec (.addr(bus_addr), .sel(sel));

    vpctl_seq u_seq (.clk(clk), .rst_n(rst_n), .launch(launch), .state(state));

    assign wr_acc  = bus_valid & bus_write;
    assign rd_acc  = bus_valid & ~bus_write;
    assign wr_bits = bus_wdata[NUM_VP-1:0];

    always_comb begin
        run_req  = '0;
        stop_req = '0;
        if (launch) run_req = START_MASK[NUM_VP-1:0];
        if (wr_acc && sel == REG_RUN)  run_req  = run_req | wr_bits;
        if (wr_acc && sel == REG_STOP) stop_req = wr_bits;
    end

    for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
        vpctl_vp_slice u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_sel   (run_req[v]),
            .stop_sel  (stop_req[v]),
            .running   (run_q[v]),
            .rst_pulse (vp_reset[v]),
            .halt_pulse(vp_halt[v])
        );
    end

    always_comb begin
        stat_word = '0;
        stat_word[NUM_VP-1:0] = run_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            rd_valid  <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            rd_valid  <= rd_acc;
            err_pulse <= bus_valid && (sel == REG_NONE);
            bus_rdata <= (rd_acc && sel == REG_STAT) ? stat_word : '0;
        end
    end
endmodule

// File: rtl/vp_run_ctl_chk.sv
module vp_run_ctl_chk #(
    parameter int unsigned NUM_VP = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic              rd_valid,
    input logic              err_pulse,
    input logic [NUM_VP-1:0] run_q,
    input logic [NUM_VP-1:0] vp_reset,
    input logic [NUM_VP-1:0] vp_halt
);
    AST_START_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        ((vp_reset & $past(run_q)) == '0) && ((vp_reset & ~run_q) == '0)); // R2
    AST_STOP_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        ((vp_halt & ~$past(run_q)) == '0) && ((vp_halt & run_q) == '0)); // R4
    AST_NO_DOUBLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (vp_reset & vp_halt) == '0); // R11
    AST_CHANGE_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((run_q ^ $past(run_q)) & ~(vp_reset | vp_halt)) == '0); // R11
    AST_READ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_valid && !bus_write)); // R6
    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(bus_valid)); // R8
endmodule

bind vp_run_ctl vp_run_ctl_chk #(.NUM_VP(NUM_VP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .rd_valid (rd_valid),
    .err_pulse(err_pulse),
    .run_q    (run_q),
    .vp_reset (vp_reset),
    .vp_halt  (vp_halt)
);

// File: tb/tb_vp_run_ctl.sv
module tb_vp_run_ctl;
    localparam int NV = 8;
    localparam logic [7:0] START = 8'h05;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        rd_valid;
    logic        err_pulse;
    logic [NV-1:0] vp_reset;
    logic [NV-1:0] vp_halt;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_run;

    always #10 clk = ~clk;

    vp_run_ctl #(.NUM_VP(NV), .DATA_W(64), .START_MASK(64'h05)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rd_valid(rd_valid), .err_pulse(err_pulse), .vp_reset(vp_reset), .vp_halt(vp_halt)
    );

    function automatic logic is_known(input logic [15:0] a);
        return (a == 16'h2028) || (a == 16'h2030) || (a == 16'h2070) ||
               (a == 16'h4028) || (a == 16'h4030) || (a == 16'h4070);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write; returns after sampling the registered outputs
    task automatic wr(input string req, input logic [15:0] a, input logic [63:0] d);
        logic [7:0] sel_bits, er, eh;
        logic       ee;
        sel_bits = d[7:0];
        er = '0; eh = '0; ee = !is_known(a);
        if (a[11:0] == 12'h028 && !ee) er = sel_bits & ~exp_run;
        if (a[11:0] == 12'h030 && !ee) eh = sel_bits & exp_run;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        check(req, {47'b0, ee, vp_reset, vp_halt}, {47'b0, ee, er, eh});
        exp_run = (exp_run | er) & ~eh;
    endtask

    task automatic rd(input string req, input logic [15:0] a);
        logic [63:0] ev;
        ev = (is_known(a) && a[11:0] == 12'h070) ? {56'b0, exp_run} : 64'b0;
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        check(req, {rd_valid, err_pulse, bus_rdata[61:0]},
                   {1'b1, !is_known(a), ev[61:0]});
        check(req, {62'b0, bus_rdata[63:62]}, {62'b0, ev[63:62]});
    endtask

    initial begin : watchdog
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [15:0] base;
        void'($urandom(32'd4711));
        exp_run = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: quiet outputs during reset
        check("R1 reset outputs", {60'b0, rd_valid, err_pulse, |vp_reset, |vp_halt}, 64'b0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 launch pulses", {48'b0, vp_reset, vp_halt}, {48'b0, START, 8'h00});
        exp_run = START;
        rd("R1 R6 status after launch", 16'h2070);
        // R3: run on already-running processor
        wr("R3 run already running", 16'h2028, 64'h01);
        // R2 with high junk bits masked
        wr("R2 run masked", 16'h4028, 64'hFFFF_FF00_0000_0F02);
        rd("R6 R7 status other window", 16'h4070);
        wr("R4 stop", 16'h2030, 64'h0000_0000_0000_0003);
        wr("R5 stop halted", 16'h4030, 64'h01);
        wr("R10 write to status ignored", 16'h2070, 64'hFF);
        rd("R10 status unchanged", 16'h2070);
        rd("R10 read run reg zero", 16'h2028);
        rd("R10 read stop reg zero", 16'h4030);
        wr("R8 unknown write", 16'h2038, 64'hFF);
        rd("R8 status after unknown", 16'h2070);
        rd("R8 unknown read", 16'h0070);

        for (int i = 0; i < 300; i++) begin
            logic [63:0] d;
            logic [15:0] a;
            d = {$urandom, $urandom};
            base = ($urandom & 1) ? 16'h4000 : 16'h2000;
            case ($urandom % 5)
                0, 1: begin a = base + 16'h0028; wr("R2 R3 R7 random run", a, d); end
                2:    begin a = base + 16'h0030; wr("R4 R5 R7 random stop", a, d); end
                3:    begin a = base + 16'h0070; rd("R6 R7 random status", a); end
                default: begin
                    a = 16'($urandom);
                    if (is_known(a)) a = a ^ 16'h0004;
                    if ($urandom & 1) wr("R8 random unknown write", a, d);
                    else              rd("R8 random unknown read", a);
                end
            endcase
        end

        // R9: stop meets launch set in the launch cycle
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 16'h2030; bus_wdata = 64'h01;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0;
        check("R9 stop wins in launch", {48'b0, vp_reset, vp_halt}, {48'b0, 8'h04, 8'h00});
        exp_run = 8'h04;
        rd("R9 status after launch stop", 16'h4070);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule